// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned 32-bit operand by another and returns both the quotient and the remainder. It uses the restoring method, one trial subtraction per clock. A double-width shift register holds the divisor. The divisor is loaded into its upper half and moves one place to the right after every trial. A double-width remainder register starts out holding the dividend. Each trial subtracts the whole divisor register from the remainder. When the difference is non-negative, it is kept and a 1 enters the quotient from the right. When the difference is negative, the remainder is left unchanged and a 0 enters the quotient. This is the same as subtracting and then adding the divisor back, but it takes no extra cycle.

Operands enter on a valid/ready channel, and results leave on a second valid/ready channel. The block accepts one operand pair and does not accept another until the result has been taken. `in_ready` is high only while the block is idle. A pair is captured on the rising edge where `in_valid` and `in_ready` are both high. The block then runs exactly W+1 trials. `out_valid` stays high until a rising edge with `out_ready` high. While the consumer holds `out_ready` low, the result does not change.

A zero divisor needs no special case: every trial succeeds. The block returns an all-ones quotient and the dividend as the remainder, with the usual latency.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: For a non-zero divisor, `out_quotient` equals floor(dividend/divisor) and `out_remainder` equals dividend mod divisor. As a result, quotient×divisor+remainder equals the dividend and the remainder is below the divisor.
- R3: For a zero divisor, `out_quotient` is 32'hFFFF_FFFF and `out_remainder` equals the dividend.
- R4: `out_valid` first reads 1 after exactly W+1 rising edges following the accepting edge (33 for W=32), whatever the operands are.
- R5: `in_ready` is 0 from the accepting edge until the result handshake. While `in_ready` is 0, `in_valid` and changes on the operand inputs have no effect on the result. `in_ready` and `out_valid` are never both 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_quotient` and `out_remainder` hold their values. After the edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle; operand pair will be taken |
| in_dividend | input | W | Dividend, unsigned |
| in_divisor | input | W | Divisor, unsigned |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | W | Quotient |
| out_remainder | output | W | Remainder |

## Verification
The hardest situation to reach from the ports is a long busy window in which the producer keeps offering new operands while the result is being back-pressured. A wrong design would capture the new pair or let the held result drift. Every directed run therefore keeps `in_valid` high with scrambled operands on the inputs for the whole computation. Chosen runs then hold `out_ready` low for several cycles and watch the result. Edge operands are also run: a zero divisor, a divisor of one, an all-ones dividend and divisor, and a divisor larger than the dividend. These push the first trial and the last trial to their extremes.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } div_state_t;
endpackage

// File: rtl/div_step_counter.sv
module div_step_counter #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic last
);
  localparam int CW = $clog2(W + 1) + 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + 1'b1;
  end

  // W+1 trials: indices 0..W
  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic last_step,
  output logic load,
  output logic step,
  output logic in_ready,
  output logic out_valid
);
  div_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid) begin
        load    = 1'b1;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        step = 1'b1;
        if (last_step) state_d = ST_HOLD;
      end
      ST_HOLD: if (out_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int DW = 2 * W;

  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [W-1:0]  quo_q;
  logic [DW:0]   trial;
  logic          negative;

  // full-width trial subtraction with a borrow bit as sign
  assign trial    = {1'b0, rem_q} - {1'b0, dvs_q};
  assign negative = trial[DW];

  always_ff @(posedge clk) begin
    if (load) begin
      rem_q <= {{W{1'b0}}, dividend};
      dvs_q <= {divisor, {W{1'b0}}};
      quo_q <= '0;
    end else if (step) begin
      // restore = keep old remainder when the trial went negative
      if (!negative) rem_q <= trial[DW-1:0];
      quo_q <= {quo_q[W-2:0], ~negative};
      dvs_q <= dvs_q >> 1;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q[W-1:0];
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder
);
  logic load, step, last_step;

  div_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .last_step (last_step),
    .load      (load),
    .step      (step),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  div_step_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (load),
    .advance (step),
    .last    (last_step)
  );

  div_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .load      (load),
    .step      (step),
    .dividend  (in_dividend),
    .divisor   (in_divisor),
    .quotient  (out_quotient),
    .remainder (out_remainder)
  );
endmodule

// File: rtl/restoring_divider_checker.sv
module restoring_divider_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_dividend,
  input logic [W-1:0] in_divisor,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_quotient,
  input logic [W-1:0] out_remainder
);
  localparam int CW = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] LAT = CW'(W + 1);

  logic [W-1:0]  a_q, b_q;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      b_q      <= '0;
      busy_cnt <= '0;
    end else if (in_valid && in_ready) begin
      a_q      <= in_dividend;
      b_q      <= in_divisor;
      busy_cnt <= '0;
    end else if (!in_ready && !out_valid) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  assert_quotient_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && b_q != '0) |->
      (({{W{1'b0}}, out_quotient} * {{W{1'b0}}, b_q} + {{W{1'b0}}, out_remainder}
        == {{W{1'b0}}, a_q}) && (out_remainder < b_q)));

  assert_div_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && b_q == '0) |-> (out_quotient == '1 && out_remainder == a_q));

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (busy_cnt == LAT));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_quotient) && $stable(out_remainder)));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

bind restoring_divider restoring_divider_checker #(.W(W)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_dividend   (in_dividend),
  .in_divisor    (in_divisor),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_quotient  (out_quotient),
  .out_remainder (out_remainder)
);

// File: tb/test_restoring_divider.sv
`timescale 1ns/1ps
module test_restoring_divider;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_quotient;
  logic [W-1:0] out_remainder;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  restoring_divider #(.W(W)) i_restoring_divider (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quotient(out_quotient), .out_remainder(out_remainder)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // one division; keeps in_valid high with junk while busy (R5),
  // stalls out_ready for 'stall' cycles (R6)
  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input int stall);
    logic [31:0] eq, er, q0, r0;
    int lat;
    if (b == 0) begin eq = 32'hFFFF_FFFF; er = a; end
    else begin eq = a / b; er = a % b; end
    @(negedge clk);
    in_valid = 1'b1; in_dividend = a; in_divisor = b; out_ready = 1'b0;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_dividend = ~a; in_divisor = b ^ 32'h5A5A_0F0F;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!out_valid && lat < 60)
        check(in_ready == 1'b0, "R5", "in_ready while busy", {63'd0, in_ready}, 64'd0);
    end while (!out_valid && lat < 60);
    in_valid = 1'b0;
    check(lat == W + 1, "R4", "latency", lat, W + 1);
    check(in_ready == 1'b0, "R5", "in_ready with result", {63'd0, in_ready}, 64'd0);
    if (b == 0) begin
      check(out_quotient == eq, "R3", "zero-divisor quotient", out_quotient, eq);
      check(out_remainder == er, "R3", "zero-divisor remainder", out_remainder, er);
    end else begin
      check(out_quotient == eq, "R2", "quotient", out_quotient, eq);
      check(out_remainder == er, "R2", "remainder", out_remainder, er);
      check({32'd0, out_quotient} * {32'd0, b} + {32'd0, out_remainder} == {32'd0, a},
            "R2", "identity q*d+r", {32'd0, out_quotient} * {32'd0, b} + {32'd0, out_remainder}, a);
      check(out_remainder < b, "R2", "remainder below divisor", out_remainder, b);
    end
    q0 = out_quotient; r0 = out_remainder;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6", "out_valid held", {63'd0, out_valid}, 64'd1);
      check(out_quotient == q0 && out_remainder == r0, "R6", "result held",
            {out_quotient, out_remainder}, {q0, r0});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R6", "release after handshake",
          {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", {63'd0, in_ready}, 64'd1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_basic();
    run_div(32'd7, 32'd2, 0);           // R2 small
    run_div(32'd1000, 32'd10, 0);       // R2 exact
    run_div(32'd74, 32'd8, 0);          // R2 with remainder
  endtask

  task automatic t_edges();
    run_div(32'hFFFF_FFFF, 32'd1, 0);           // R2 divisor one
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R2 equal max
    run_div(32'd5, 32'hFFFF_FFFF, 0);           // R2 divisor > dividend
    run_div(32'h8000_0000, 32'h8000_0001, 0);   // R2 just below
    run_div(32'd0, 32'd9, 0);                   // R2 zero dividend
  endtask

  task automatic t_div_zero();
    run_div(32'hDEAD_BEEF, 32'd0, 0);   // R3
    run_div(32'd0, 32'd0, 0);           // R3
  endtask

  task automatic t_backpressure();
    run_div(32'd123_456_789, 32'd1_000, 5);  // R6
    run_div(32'hCAFE_F00D, 32'd0, 3);        // R6 with R3
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a, b;
      a = next_rand();
      b = next_rand() >> (next_rand() & 32'd31);
      run_div(a, b, k % 3);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_edges();
    t_div_zero();
    t_backpressure();
    t_random();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule